// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of an asynchronous NOR flash model. The host talks to it through chip-enable, output-enable and write-enable strobes, an address bus and a 16-bit data bus. Each write carries an 8-bit command code in the low data byte. Commands that take one write change what later reads return: array words, identifier words, query words or the status byte. Commands that take two writes start a word program or a block erase, lock or unlock a block, or load the read configuration word.

Program and erase requests go to a small write engine. The engine owns a behavioral word array and takes a fixed number of clock cycles per operation. It reports busy, suspended and program-error flags back to the command side. The status byte combines these live flags with sticky error bits. It is captured once, on the clock edge where a read begins, so it stays constant for the whole read strobe.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write is taken on the first rising clock edge at which CE# and WE# are both sampled low. Only dq_in[7:0] forms the command code, so dq_in[15:8] has no effect on a command write.
- R2: Code FFh selects array reads, 90h identifier reads and 98h query reads. In identifier mode, addr[1:0] = 0 returns MFR_CODE, 1 returns DEV_CODE, 2 returns {lockdown, lock} of the addressed block in bits [1:0], and 3 returns the configuration word. Query mode returns 0051h, 0052h and 0059h at addresses 10h, 11h and 12h, and 0000h at every other address.
- R3: Code 70h selects status reads. The status byte has bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 2 program suspended and bit 1 lock violation; the other bits read 0. During a status read, dq_out[15:8] is 00h.
- R4: The status byte is captured on the first rising edge at which CE# and OE# are both low. It stays unchanged on dq_out for as long as both stay low, even when the engine finishes during the read.
- R5: Code 50h clears bits 5, 4 and 1 and keeps the read mode. When an error is set on the same edge that a clear is taken, the error bit ends up set.
- R6: Code 40h or 10h followed by one data write programs the addressed word with old AND new. The engine is busy for PROG_CYC edges. Asking to turn any 0 bit into 1 sets bit 4. After a program or erase sequence, reads return status.
- R7: Code 20h followed by D0h erases the addressed block to FFFFh, one word per cycle. Code 20h followed by any other code cancels the erase and sets bits 5 and 4.
- R8: Code 60h followed by 01h locks the addressed block, D0h unlocks it, 2Fh locks it and locks it down, and 03h loads the configuration word from the address bus. Any other second code sets bits 5 and 4.
- R9: A program or erase aimed at a locked block does not start. It sets bit 1 and leaves the array unchanged.
- R10: The lockdown bit of a block cannot be cleared, and an unlock of a locked-down block has no effect, until reset.
- R11: Code B0h suspends a running operation: ready reads 1, bit 6 or bit 2 is set, and the array stops changing. Code D0h with no sequence pending resumes the operation, which then completes.
- R12: While an operation is running or suspended, codes 20h, 40h and 10h are ignored, and the next write is decoded as a new command.
- R13: After reset: array read mode, status 80h, all blocks unlocked and not locked down, every word FFFFh, configuration word 0000h.
- R14: dq_oe is high exactly while CE# and OE# are both low; otherwise dq_out is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the bus strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address; the top BLK_W bits select the block |
| dq_in | input | 16 | Write data; the low byte carries command codes |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | High while dq_out is driven |

## Verification
The sharpest collision is a clear-status command that arrives on the same edge where the engine finishes a faulty program and raises the program error. The bench times the 50h write so that it is taken exactly PROG_CYC edges after the program's data write, then reads status and expects bit 4 still set. A second 50h one cycle later must clear it. A second collision puts the start of a status read ahead of the engine finishing, with the read strobe held through completion: the captured busy value must stay on dq_out, and only a fresh read may show ready.

// File: rtl/fcsm_pkg.sv
// Package: shared types and constants for the flash command interface.
// Assumes 8-bit command codes carried on the low data byte.
package fcsm_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_QUERY  = 2'd2,
        RD_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_PROG  = 2'd2,
        SEQ_CFG   = 2'd3
    } seq_e;

    // Command codes
    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_PROG    = 8'h40;
    localparam logic [7:0] OP_PROG_B  = 8'h10;
    localparam logic [7:0] OP_CONFIG  = 8'h60;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_LOCK    = 8'h01;
    localparam logic [7:0] OP_LOCKDN  = 8'h2F;
    localparam logic [7:0] OP_RCFG    = 8'h03;

    // Status byte bit positions
    localparam int ST_READY   = 7;
    localparam int ST_ESUSP   = 6;
    localparam int ST_EERR    = 5;
    localparam int ST_PERR    = 4;
    localparam int ST_PSUSP   = 2;
    localparam int ST_LOCKV   = 1;

endpackage

// File: rtl/fcsm_bus_sync.sv
// Module: strobe sampler. Turns the asynchronous-style bus strobes into
// clock-domain write-start, read-active and read-start indications.
// Assumes the host holds each strobe for at least one clock edge.
module fcsm_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start,
    output logic rd_active,
    output logic rd_start
);
    logic wr_now;
    logic wr_prev;
    logic rd_prev;

    assign wr_now    = ~ce_n & ~we_n;
    assign rd_active = ~ce_n & ~oe_n;
    assign wr_start  = wr_now & ~wr_prev;
    assign rd_start  = rd_active & ~rd_prev;

    // Remember last sampled strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b0;
            rd_prev <= 1'b0;
        end else begin
            wr_prev <= wr_now;
            rd_prev <= rd_active;
        end
    end
endmodule

// File: rtl/fcsm_cmd_decode.sv
// Module: command sequencer. Decodes one- and two-write command sequences,
// holds the read mode, the block lock bits and the configuration word, and
// issues start, suspend and resume pulses to the write engine.
// Assumes wr_start is a single-cycle pulse per bus write.
module fcsm_cmd_decode
    import fcsm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd,
    input  logic              wsm_busy,
    input  logic              wsm_susp,
    output rd_mode_e          rd_mode,
    output logic              start_prog,
    output logic              start_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic              clr_err,
    output logic              seq_err,
    output logic              lock_viol,
    output logic [(1<<BLK_W)-1:0] lock_vec,
    output logic [(1<<BLK_W)-1:0] lkdn_vec,
    output logic [DATA_W-1:0] rcfg
);
    localparam int NBLK = 1 << BLK_W;

    seq_e            seq_q, seq_d;
    rd_mode_e        mode_d;
    logic [BLK_W-1:0] blk;
    logic            lock_set, lock_clr, lkdn_set, rcfg_load;
    logic            running;
    logic            tgt_locked;

    assign blk        = addr[ADDR_W-1 -: BLK_W];
    assign running    = wsm_busy & ~wsm_susp;
    assign tgt_locked = lock_vec[blk];

    // Decode the current write against the pending sequence
    always_comb begin
        seq_d       = seq_q;
        mode_d      = rd_mode;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        req_suspend = 1'b0;
        req_resume  = 1'b0;
        clr_err     = 1'b0;
        seq_err     = 1'b0;
        lock_viol   = 1'b0;
        lock_set    = 1'b0;
        lock_clr    = 1'b0;
        lkdn_set    = 1'b0;
        rcfg_load   = 1'b0;
        if (wr_start) begin
            case (seq_q)
                SEQ_IDLE: begin
                    case (cmd)
                        OP_ARRAY:  mode_d = RD_ARRAY;
                        OP_IDENT:  mode_d = RD_IDENT;
                        OP_QUERY:  mode_d = RD_QUERY;
                        OP_STATUS: mode_d = RD_STATUS;
                        OP_CLEAR:  clr_err = 1'b1;
                        OP_ERASE: begin
                            if (!wsm_busy) begin
                                seq_d  = SEQ_ERASE;
                                mode_d = RD_STATUS;
                            end
                        end
                        OP_PROG, OP_PROG_B: begin
                            if (!wsm_busy) begin
                                seq_d  = SEQ_PROG;
                                mode_d = RD_STATUS;
                            end
                        end
                        OP_CONFIG: seq_d = SEQ_CFG;
                        OP_SUSPEND: begin
                            mode_d      = RD_STATUS;
                            req_suspend = running;
                        end
                        OP_CONFIRM: begin
                            mode_d     = RD_STATUS;
                            req_resume = wsm_susp;
                        end
                        default: ;
                    endcase
                end
                SEQ_ERASE: begin
                    seq_d  = SEQ_IDLE;
                    mode_d = RD_STATUS;
                    if (cmd != OP_CONFIRM) begin
                        seq_err = 1'b1;
                    end else if (tgt_locked) begin
                        lock_viol = 1'b1;
                    end else begin
                        start_erase = 1'b1;
                    end
                end
                SEQ_PROG: begin
                    seq_d  = SEQ_IDLE;
                    mode_d = RD_STATUS;
                    if (tgt_locked) begin
                        lock_viol = 1'b1;
                    end else begin
                        start_prog = 1'b1;
                    end
                end
                default: begin
                    seq_d = SEQ_IDLE;
                    case (cmd)
                        OP_LOCK:    lock_set = 1'b1;
                        OP_CONFIRM: lock_clr = ~lkdn_vec[blk];
                        OP_LOCKDN: begin
                            lock_set = 1'b1;
                            lkdn_set = 1'b1;
                        end
                        OP_RCFG:    rcfg_load = 1'b1;
                        default:    seq_err = 1'b1;
                    endcase
                end
            endcase
        end
    end

    // Sequence state and read mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SEQ_IDLE;
            rd_mode <= RD_ARRAY;
            rcfg    <= '0;
        end else begin
            seq_q   <= seq_d;
            rd_mode <= mode_d;
            if (rcfg_load) begin
                rcfg <= DATA_W'(addr);
            end
        end
    end

    // Per-block lock and lockdown bits
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_vec[b] <= 1'b0;
                lkdn_vec[b] <= 1'b0;
            end else if (blk == BLK_W'(b)) begin
                if (lock_set) begin
                    lock_vec[b] <= 1'b1;
                end else if (lock_clr) begin
                    lock_vec[b] <= 1'b0;
                end
                if (lkdn_set) begin
                    lkdn_vec[b] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fcsm_wsm.sv
// Module: write engine model. Runs word program and block erase over a
// behavioral array, supports suspend and resume, and flags program faults.
// Assumes start pulses arrive only while the engine is idle.
module fcsm_wsm #(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 2,
    parameter int DATA_W   = 16,
    parameter int PROG_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              suspend,
    input  logic              resume,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              susp,
    output logic              erase_op,
    output logic              prog_fault
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int OFF_W     = ADDR_W - BLK_W;
    localparam int BLK_WORDS = 1 << OFF_W;
    localparam int CNT_MAX   = (PROG_CYC > BLK_WORDS) ? PROG_CYC : BLK_WORDS;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data;
    logic [CNT_W-1:0]  cnt;
    logic              step;
    logic              last;
    logic [DATA_W-1:0] merged;

    assign step       = busy & ~susp;
    assign last       = step && (cnt == '0);
    assign merged     = mem[tgt_addr] & tgt_data;
    assign prog_fault = last & ~erase_op & (merged != tgt_data);
    assign rd_data    = mem[rd_addr];

    // Operation sequencing and array updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            erase_op <= 1'b0;
            tgt_addr <= '0;
            tgt_data <= '0;
            cnt      <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (start_erase) begin
            busy     <= 1'b1;
            erase_op <= 1'b1;
            tgt_addr <= {cmd_addr[ADDR_W-1 -: BLK_W], {OFF_W{1'b0}}};
            cnt      <= CNT_W'(BLK_WORDS - 1);
        end else if (start_prog) begin
            busy     <= 1'b1;
            erase_op <= 1'b0;
            tgt_addr <= cmd_addr;
            tgt_data <= cmd_data;
            cnt      <= CNT_W'(PROG_CYC - 1);
        end else if (step) begin
            if (erase_op) begin
                mem[tgt_addr] <= '1;
                tgt_addr      <= tgt_addr + 1'b1;
            end else if (cnt == '0) begin
                mem[tgt_addr] <= merged;
            end
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Suspend flag follows suspend and resume requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp <= 1'b0;
        end else if (suspend && step && !last) begin
            susp <= 1'b1;
        end else if (resume && susp) begin
            susp <= 1'b0;
        end
    end
endmodule

// File: rtl/fcsm_status.sv
// Module: status byte builder. Keeps sticky error bits and merges them with
// the live engine flags. Assumes a set on the same edge as a clear wins.
module fcsm_status
    import fcsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_err,
    input  logic       seq_err,
    input  logic       lock_viol,
    input  logic       prog_fault,
    input  logic       wsm_busy,
    input  logic       wsm_susp,
    input  logic       wsm_erase,
    output logic [7:0] status
);
    logic eerr_q, perr_q, lockv_q;

    // Sticky error bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eerr_q  <= 1'b0;
            perr_q  <= 1'b0;
            lockv_q <= 1'b0;
        end else begin
            eerr_q  <= seq_err | (eerr_q & ~clr_err);
            perr_q  <= seq_err | prog_fault | (perr_q & ~clr_err);
            lockv_q <= lock_viol | (lockv_q & ~clr_err);
        end
    end

    // Assemble the live status byte
    always_comb begin
        status           = 8'h00;
        status[ST_READY] = ~wsm_busy | wsm_susp;
        status[ST_ESUSP] = wsm_susp & wsm_erase;
        status[ST_EERR]  = eerr_q;
        status[ST_PERR]  = perr_q;
        status[ST_PSUSP] = wsm_susp & ~wsm_erase;
        status[ST_LOCKV] = lockv_q;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: top of the flash command interface. Connects strobe sampling,
// command decode, write engine and status, captures status at read start
// and steers the read data bus. Assumes a 16-bit data bus.
module flash_cmd_ctrl
    import fcsm_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          BLK_W    = 2,
    parameter int          PROG_CYC = 4,
    parameter logic [15:0] MFR_CODE = 16'h00C3,
    parameter logic [15:0] DEV_CODE = 16'h5A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic              dq_oe
);
    localparam int DATA_W = 16;
    localparam int NBLK   = 1 << BLK_W;

    logic              wr_start, rd_active, rd_start;
    rd_mode_e          rd_mode;
    logic              start_prog, start_erase, req_suspend, req_resume;
    logic              clr_err, seq_err, lock_viol;
    logic [NBLK-1:0]   lock_vec, lkdn_vec;
    logic [DATA_W-1:0] rcfg;
    logic [DATA_W-1:0] arr_data;
    logic              wsm_busy, wsm_susp, wsm_erase, prog_fault;
    logic [7:0]        live_status;
    logic [7:0]        srd_q;
    logic [BLK_W-1:0]  cur_blk;
    logic [DATA_W-1:0] query_word;
    logic [DATA_W-1:0] ident_word;

    assign cur_blk = addr[ADDR_W-1 -: BLK_W];

    fcsm_bus_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .wr_start  (wr_start),
        .rd_active (rd_active),
        .rd_start  (rd_start)
    );

    fcsm_cmd_decode #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start    (wr_start),
        .addr        (addr),
        .cmd         (dq_in[7:0]),
        .wsm_busy    (wsm_busy),
        .wsm_susp    (wsm_susp),
        .rd_mode     (rd_mode),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .req_suspend (req_suspend),
        .req_resume  (req_resume),
        .clr_err     (clr_err),
        .seq_err     (seq_err),
        .lock_viol   (lock_viol),
        .lock_vec    (lock_vec),
        .lkdn_vec    (lkdn_vec),
        .rcfg        (rcfg)
    );

    fcsm_wsm #(
        .ADDR_W   (ADDR_W),
        .BLK_W    (BLK_W),
        .DATA_W   (DATA_W),
        .PROG_CYC (PROG_CYC)
    ) u_wsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .suspend     (req_suspend),
        .resume      (req_resume),
        .cmd_addr    (addr),
        .cmd_data    (dq_in),
        .rd_addr     (addr),
        .rd_data     (arr_data),
        .busy        (wsm_busy),
        .susp        (wsm_susp),
        .erase_op    (wsm_erase),
        .prog_fault  (prog_fault)
    );

    fcsm_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_err    (clr_err),
        .seq_err    (seq_err),
        .lock_viol  (lock_viol),
        .prog_fault (prog_fault),
        .wsm_busy   (wsm_busy),
        .wsm_susp   (wsm_susp),
        .wsm_erase  (wsm_erase),
        .status     (live_status)
    );

    // Freeze the status byte on the edge that opens a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srd_q <= 8'h80;
        end else if (rd_start) begin
            srd_q <= live_status;
        end
    end

    // Query words for the small fixed table
    always_comb begin
        if (addr == ADDR_W'(16)) begin
            query_word = 16'h0051;
        end else if (addr == ADDR_W'(17)) begin
            query_word = 16'h0052;
        end else if (addr == ADDR_W'(18)) begin
            query_word = 16'h0059;
        end else begin
            query_word = 16'h0000;
        end
    end

    // Identifier words selected by the low address bits
    always_comb begin
        case (addr[1:0])
            2'd0:    ident_word = MFR_CODE;
            2'd1:    ident_word = DEV_CODE;
            2'd2:    ident_word = {14'd0, lkdn_vec[cur_blk], lock_vec[cur_blk]};
            default: ident_word = rcfg;
        endcase
    end

    // Read data steering
    always_comb begin
        dq_out = '0;
        if (rd_active) begin
            case (rd_mode)
                RD_ARRAY:  dq_out = arr_data;
                RD_IDENT:  dq_out = ident_word;
                RD_QUERY:  dq_out = query_word;
                default:   dq_out = {8'h00, srd_q};
            endcase
        end
    end

    assign dq_oe = rd_active;
endmodule

// File: rtl/fcsm_checker.sv
// Module: property checker for the flash command interface, bound to the top.
module fcsm_checker
    import fcsm_pkg::*;
#(
    parameter int BLK_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dq_oe,
    input logic [15:0]           dq_out,
    input logic                  rd_active,
    input rd_mode_e              rd_mode,
    input logic                  start_prog,
    input logic                  start_erase,
    input logic                  wsm_busy,
    input logic [(1<<BLK_W)-1:0] lock_vec,
    input logic [(1<<BLK_W)-1:0] lkdn_vec,
    input logic [BLK_W-1:0]      cur_blk,
    input logic [7:0]            live_status,
    input logic                  clr_err
);
    logic [1:0] since_rst;

    // Count edges since reset so history checks stay inside it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == 16'h0000); // R14

    AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && rd_mode == RD_STATUS) |-> dq_out[15:8] == 8'h00); // R3

    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && rd_active && $past(rd_active) && $past(rd_active, 2)
         && rd_mode == RD_STATUS && $past(rd_mode) == RD_STATUS) |-> $stable(dq_out)); // R4

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> !wsm_busy); // R12

    AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> !lock_vec[cur_blk]); // R9

    AST_LOCKDOWN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1) |-> (($past(lkdn_vec) & ~lkdn_vec) == '0)); // R10

    AST_LOCKDOWN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lkdn_vec & ~lock_vec) == '0); // R10

    AST_PERR_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $fell(live_status[ST_PERR])) |-> $past(clr_err)); // R5
endmodule

bind flash_cmd_ctrl fcsm_checker #(.BLK_W(BLK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dq_oe       (dq_oe),
    .dq_out      (dq_out),
    .rd_active   (rd_active),
    .rd_mode     (rd_mode),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .wsm_busy    (wsm_busy),
    .lock_vec    (lock_vec),
    .lkdn_vec    (lkdn_vec),
    .cur_blk     (cur_blk),
    .live_status (live_status),
    .clr_err     (clr_err)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    localparam int PROG_CYC = 4;
    localparam logic [15:0] MFR = 16'h00C3;
    localparam logic [15:0] DEV = 16'h5A17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.PROG_CYC(PROG_CYC)) u_flash_cmd_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .addr   (addr),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = dq_out;
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R14 idle dq_oe", {15'd0, dq_oe}, 16'h0000);
        chk("R14 idle dq_out", dq_out, 16'h0000);
        ce_n = 1'b0; oe_n = 1'b0; addr = 8'h05;
        @(negedge clk);
        chk("R14 read dq_oe", {15'd0, dq_oe}, 16'h0001);
        chk("R13 array word", dq_out, 16'hFFFF);
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        wr(8'h00, 16'h0090);
        chk_rd("R13 unlocked", 8'h82, 16'h0000);
        chk_rd("R13 config word", 8'h03, 16'h0000);
        wr(8'h00, 16'h0070);
        chk_rd("R13 status", 8'h00, 16'h0080);
    endtask

    task automatic t_modes();
        wr(8'h00, 16'h0090);
        chk_rd("R2 mfr", 8'h00, MFR);
        chk_rd("R2 dev", 8'h01, DEV);
        wr(8'h00, 16'h0098);
        chk_rd("R2 query 10h", 8'h10, 16'h0051);
        chk_rd("R2 query 12h", 8'h12, 16'h0059);
        chk_rd("R2 query other", 8'h13, 16'h0000);
        wr(8'h00, 16'hAB70);
        chk_rd("R1 upper byte ignored status", 8'h00, 16'h0080);
        wr(8'h00, 16'h12FF);
        chk_rd("R1 upper byte ignored array", 8'h07, 16'hFFFF);
    endtask

    task automatic t_program();
        wr(8'h05, 16'h0040);
        wr(8'h05, 16'h1234);
        chk_rd("R6 busy status", 8'h00, 16'h0000);
        repeat (6) @(negedge clk);
        chk_rd("R6 done status", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        chk_rd("R6 word programmed", 8'h05, 16'h1234);
        wr(8'h06, 16'h0010);
        wr(8'h06, 16'h00F0);
        repeat (6) @(negedge clk);
        wr(8'h00, 16'h00FF);
        chk_rd("R6 alternate setup", 8'h06, 16'h00F0);
    endtask

    task automatic t_clear_collision();
        wr(8'h05, 16'h0040);
        wr(8'h05, 16'hFFFF);
        repeat (PROG_CYC - 2) @(negedge clk);
        wr(8'h00, 16'h0050);
        chk_rd("R5 set wins over clear", 8'h00, 16'h0090);
        wr(8'h00, 16'h0050);
        chk_rd("R5 clear", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        chk_rd("R6 faulty program keeps AND", 8'h05, 16'h1234);
        wr(8'h00, 16'h0050);
        chk_rd("R5 mode kept after clear", 8'h05, 16'h1234);
    endtask

    task automatic t_bad_sequences();
        wr(8'h40, 16'h0020);
        wr(8'h40, 16'h0055);
        chk_rd("R7 cancelled erase error", 8'h00, 16'h00B0);
        wr(8'h00, 16'h0050);
        chk_rd("R5 clear after cancel", 8'h00, 16'h0080);
        wr(8'h40, 16'h0060);
        wr(8'h40, 16'h0077);
        chk_rd("R8 bad config code", 8'h00, 16'h00B0);
        wr(8'h00, 16'h0050);
    endtask

    task automatic t_erase_suspend();
        logic [15:0] first;
        logic [15:0] held;
        wr(8'h45, 16'h0040);
        wr(8'h45, 16'h0F0F);
        repeat (6) @(negedge clk);
        wr(8'h40, 16'h0020);
        wr(8'h40, 16'h00D0);
        chk_rd("R7 erase busy", 8'h00, 16'h0000);
        wr(8'h00, 16'h00B0);
        chk_rd("R11 erase suspended", 8'h00, 16'h00C0);
        wr(8'h46, 16'h0040);
        wr(8'h46, 16'h00FF);
        chk_rd("R12 setup ignored while suspended", 8'h05, 16'h1234);
        chk_rd("R11 array frozen in suspend", 8'h45, 16'h0F0F);
        wr(8'h00, 16'h00D0);
        ce_n = 1'b0; oe_n = 1'b0; addr = 8'h00;
        @(negedge clk);
        first = dq_out;
        held = first;
        chk("R11 resumed busy", first, 16'h0000);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (dq_out !== first) held = dq_out;
        end
        chk("R4 status held during read", held, 16'h0000);
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        chk_rd("R4 new read shows ready", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        chk_rd("R7 block erased", 8'h45, 16'hFFFF);
        chk_rd("R7 last block word", 8'h7F, 16'hFFFF);
        chk_rd("R7 other block kept", 8'h05, 16'h1234);
    endtask

    task automatic t_locks();
        wr(8'h80, 16'h0060);
        wr(8'h80, 16'h0001);
        wr(8'h00, 16'h0090);
        chk_rd("R8 lock set", 8'h82, 16'h0001);
        wr(8'h85, 16'h0040);
        wr(8'h85, 16'h0000);
        chk_rd("R9 program locked", 8'h00, 16'h0082);
        wr(8'h00, 16'h00FF);
        chk_rd("R9 array unchanged", 8'h85, 16'hFFFF);
        wr(8'h00, 16'h0050);
        wr(8'h80, 16'h0020);
        wr(8'h80, 16'h00D0);
        chk_rd("R9 erase locked", 8'h00, 16'h0082);
        wr(8'h00, 16'h0050);
        wr(8'h80, 16'h0060);
        wr(8'h80, 16'h00D0);
        wr(8'h00, 16'h0090);
        chk_rd("R8 unlock", 8'h82, 16'h0000);
        wr(8'hC0, 16'h0060);
        wr(8'hC0, 16'h002F);
        wr(8'hC0, 16'h0060);
        wr(8'hC0, 16'h00D0);
        wr(8'h00, 16'h0090);
        chk_rd("R10 lockdown holds", 8'hC2, 16'h0003);
        wr(8'h5A, 16'h0060);
        wr(8'h5A, 16'h0003);
        wr(8'h00, 16'h0090);
        chk_rd("R8 config word load", 8'h03, 16'h005A);
        do_reset();
        wr(8'h00, 16'h0090);
        chk_rd("R10 reset releases lockdown", 8'hC2, 16'h0000);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_modes();
        t_program();
        t_clear_collision();
        t_bad_sequences();
        t_erase_suspend();
        t_locks();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule